// File: doc/BRIEF.md
# Guard-Interval Window Capture Unit

This block sits beside a multi-antenna OFDM receiver and watches the symbol-aligned stream of complex baseband samples arriving from four antenna branches. Each received symbol begins with a guard interval that repeats the final stretch of the useful part. The unit picks out both copies for every branch: the leading guard interval and the trailing segment it duplicates. It writes them into a word-addressed sample buffer, so that software computing beamforming weights can correlate the two windows.

Each input sample carries one 32-bit complex word per branch. The four branch words are written through a single buffer write port on four consecutive cycles. The head window occupies the lower half of the used buffer area and the tail window the upper half. Inside each half the branches sit in ascending order, one block of guard-interval length each. When the last branch word of the final tail sample has been written, the unit raises a one-cycle done strobe. A new symbol-start pulse at any point restarts the count and abandons the capture in progress.

Top module: `gicap_top`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the write enable and the done strobe are low.
- R2: A sample with index i inside the head window (0 <= i < GI_LEN) writes branch b's word (bits b*SAMP_W upward of the sample bus) to address b*GI_LEN + i.
- R3: A sample with index i inside the tail window (USEFUL_LEN <= i < GI_LEN+USEFUL_LEN) writes branch b's word to address NUM_BR*GI_LEN + b*GI_LEN + (i - USEFUL_LEN).
- R4: Samples whose index falls between the two windows produce no buffer writes.
- R5: An accepted sample produces exactly NUM_BR writes, branch 0 first, on consecutive cycles, with the first write in the cycle after the sample is presented.
- R6: Cycles with sample-valid low are ignored: they produce no writes and do not advance the sample index, whatever the sample bus carries.
- R7: A symbol-start pulse in the middle of a symbol restarts the index at zero. Branch writes still pending for the interrupted sample are cancelled, and no done strobe is raised for the abandoned symbol.
- R8: The done strobe is high for exactly one cycle, the cycle after the last branch write of the final tail sample (index GI_LEN+USEFUL_LEN-1).
- R9: Valid samples are ignored until a symbol-start pulse has been seen after reset. They are also ignored once a symbol has been fully counted and until the next symbol-start pulse.
- R10: A sample presented in the same cycle as a symbol-start pulse is index 0 of the new symbol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_start_i | input | 1 | One-cycle pulse marking the first sample slot of a symbol |
| smp_valid_i | input | 1 | A sample for all branches is present on the bus |
| smp_bus_i | input | NUM_BR*SAMP_W | Branch samples; branch b at bits b*SAMP_W upward |
| buf_we_o | output | 1 | Buffer write enable |
| buf_addr_o | output | ADDR_W | Buffer word address |
| buf_wdata_o | output | SAMP_W | Buffer write data |
| done_o | output | 1 | One-cycle strobe after the last tail word is written |

## Verification
The assertions assume that accepted samples are spaced at least NUM_BR cycles apart, so that the branch writes of one sample end before the next sample is latched. A load during an earlier slot is flagged as a stimulus fault and not as a design fault. The bench keeps every pair of valid samples at least four cycles apart, sometimes much further. It drives changing garbage on the bus in the idle cycles between samples. The only thing it places in the cycle right after a sample is a symbol-start pulse, which is used to test cancellation.

// File: rtl/gicap_pkg.sv
// Package: shared definitions for the guard-interval capture unit.
// Assumes nothing beyond being compiled before the modules that import it.
package gicap_pkg;

    // Window selector; the encoding matches the window bit of the buffer address.
    typedef enum logic {
        WIN_HEAD = 1'b0,
        WIN_TAIL = 1'b1
    } win_e;

    // Width of a branch slot counter; at least one bit.
    function automatic int slot_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/gicap_index_tracker.sv
// Module: gicap_index_tracker
// Counts the valid samples of the current symbol and decides for each one whether
// it lies in the head or the tail window. For a captured sample it gives the
// branch-0 buffer address. Assumes symbol-start is a single-cycle pulse and that
// a sample presented together with it is index 0. After the last sample of a
// symbol the tracker goes idle until the next symbol-start.
module gicap_index_tracker
    import gicap_pkg::*;
#(
    parameter int GI_LEN     = 512,
    parameter int USEFUL_LEN = 8192,
    parameter int NUM_BR     = 4,
    parameter int ADDR_W     = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_i,
    input  logic              valid_i,
    output logic              cap_o,
    output logic [ADDR_W-1:0] base_o,
    output logic              last_o
);

    localparam int SYM_LEN   = GI_LEN + USEFUL_LEN;
    localparam int IDX_W     = $clog2(SYM_LEN);
    localparam int TAIL_BASE = NUM_BR * GI_LEN;

    logic [IDX_W-1:0] idx_q;
    logic             armed_q;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] off;
    logic             live;
    logic             in_head;
    win_e             win;

    // Classify the sample on the bus this cycle and form its branch-0 address.
    always_comb begin
        cur_idx = sof_i ? '0 : idx_q;
        live    = sof_i | armed_q;
        in_head = cur_idx < IDX_W'(GI_LEN);
        win     = (cur_idx >= IDX_W'(USEFUL_LEN)) ? WIN_TAIL : WIN_HEAD;
        off     = (win == WIN_TAIL) ? (cur_idx - IDX_W'(USEFUL_LEN)) : cur_idx;
        cap_o   = valid_i & live & (in_head | (win == WIN_TAIL));
        base_o  = ((win == WIN_TAIL) ? ADDR_W'(TAIL_BASE) : '0) + ADDR_W'(off);
        last_o  = cur_idx == IDX_W'(SYM_LEN - 1);
    end

    // Advance the index on valid samples; restart on symbol-start; idle after the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            armed_q <= 1'b0;
        end else if (sof_i) begin
            armed_q <= 1'b1;
            idx_q   <= valid_i ? IDX_W'(1) : '0;
        end else if (valid_i && armed_q) begin
            if (idx_q == IDX_W'(SYM_LEN - 1)) begin
                armed_q <= 1'b0;
                idx_q   <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // R6: the index stays inside the symbol while counting.
    assert_idx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (idx_q <= IDX_W'(SYM_LEN - 1)));

    // R6: a cycle with neither valid nor symbol-start leaves the count untouched.
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !sof_i) |=> ($stable(idx_q) && $stable(armed_q)));

endmodule

// File: rtl/gicap_branch_serializer.sv
// Module: gicap_branch_serializer
// Latches all branch words of a captured sample and sends them one per cycle
// through a single write port, branch 0 first. Branch b goes to the base address
// plus b*GI_LEN. Assumes loads arrive at least NUM_BR cycles apart. An abort
// (symbol-start) cancels the words not yet sent; a load in the same cycle wins.
module gicap_branch_serializer
    import gicap_pkg::*;
#(
    parameter int NUM_BR = 4,
    parameter int SAMP_W = 32,
    parameter int GI_LEN = 512,
    parameter int ADDR_W = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic                     abort_i,
    input  logic [ADDR_W-1:0]        base_i,
    input  logic                     last_i,
    input  logic [NUM_BR*SAMP_W-1:0] smp_i,
    output logic                     wr_en_o,
    output logic [ADDR_W-1:0]        wr_addr_o,
    output logic [SAMP_W-1:0]        wr_data_o,
    output logic                     done_o
);

    localparam int SLOT_W = slot_bits(NUM_BR);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_BR - 1);

    logic [SAMP_W-1:0] lane_in  [NUM_BR];
    logic [SAMP_W-1:0] hold_q   [NUM_BR];
    logic [ADDR_W-1:0] lane_off [NUM_BR];
    logic              busy_q;
    logic [SLOT_W-1:0] slot_q;
    logic [ADDR_W-1:0] base_q;
    logic              last_q;
    logic              done_q;

    // Split the bus into branch lanes and give each lane its block offset.
    for (genvar b = 0; b < NUM_BR; b++) begin : g_lane
        assign lane_in[b]  = smp_i[b*SAMP_W +: SAMP_W];
        assign lane_off[b] = ADDR_W'(b * GI_LEN);

        // Hold this branch's word until its slot comes up.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[b] <= '0;
            end else if (load_i) begin
                hold_q[b] <= lane_in[b];
            end
        end
    end

    // Step through the branch slots of a latched sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            slot_q <= '0;
            base_q <= '0;
            last_q <= 1'b0;
        end else if (load_i) begin
            busy_q <= 1'b1;
            slot_q <= '0;
            base_q <= base_i;
            last_q <= last_i;
        end else if (abort_i) begin
            busy_q <= 1'b0;
            slot_q <= '0;
        end else if (busy_q) begin
            if (slot_q == LAST_SLOT) begin
                busy_q <= 1'b0;
                slot_q <= '0;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    // Raise done in the cycle after the final branch word of the final sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= busy_q && (slot_q == LAST_SLOT) && last_q;
        end
    end

    // Present the word of the current slot on the write port.
    always_comb begin
        wr_en_o   = busy_q;
        wr_data_o = hold_q[slot_q];
        wr_addr_o = base_q + lane_off[slot_q];
        done_o    = done_q;
    end

    // R5: a new sample only arrives when the previous one is on its last slot or finished.
    assert_load_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (!busy_q || (slot_q == LAST_SLOT)));

    // R5: undisturbed slots advance by one each cycle.
    assert_slot_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (slot_q != LAST_SLOT) && !load_i && !abort_i)
        |=> (busy_q && (slot_q == SLOT_W'($past(slot_q) + 1'b1))));

    // R8: done never lasts two cycles.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/gicap_top.sv
// Module: gicap_top
// Guard-interval window capture unit. Tracks the sample index in each symbol
// and captures the head guard interval and the matching tail of the useful part
// for all branches into one buffer write port. Signals completion with a
// one-cycle strobe. Assumes valid samples are at least NUM_BR cycles apart and
// that ADDR_W covers 2*NUM_BR*GI_LEN words.
module gicap_top #(
    parameter int NUM_BR     = 4,
    parameter int SAMP_W     = 32,
    parameter int GI_LEN     = 512,
    parameter int USEFUL_LEN = 8192,
    parameter int ADDR_W     = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sym_start_i,
    input  logic                     smp_valid_i,
    input  logic [NUM_BR*SAMP_W-1:0] smp_bus_i,
    output logic                     buf_we_o,
    output logic [ADDR_W-1:0]        buf_addr_o,
    output logic [SAMP_W-1:0]        buf_wdata_o,
    output logic                     done_o
);

    localparam int USED_WORDS = 2 * NUM_BR * GI_LEN;
    localparam logic [ADDR_W-1:0] FINAL_ADDR = ADDR_W'(USED_WORDS - 1);

    logic              cap;
    logic [ADDR_W-1:0] base;
    logic              last;

    gicap_index_tracker #(
        .GI_LEN     (GI_LEN),
        .USEFUL_LEN (USEFUL_LEN),
        .NUM_BR     (NUM_BR),
        .ADDR_W     (ADDR_W)
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof_i   (sym_start_i),
        .valid_i (smp_valid_i),
        .cap_o   (cap),
        .base_o  (base),
        .last_o  (last)
    );

    gicap_branch_serializer #(
        .NUM_BR (NUM_BR),
        .SAMP_W (SAMP_W),
        .GI_LEN (GI_LEN),
        .ADDR_W (ADDR_W)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (cap),
        .abort_i   (sym_start_i),
        .base_i    (base),
        .last_i    (last),
        .smp_i     (smp_bus_i),
        .wr_en_o   (buf_we_o),
        .wr_addr_o (buf_addr_o),
        .wr_data_o (buf_wdata_o),
        .done_o    (done_o)
    );

    // R8: done comes right after a write to the highest used address.
    assert_done_after_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(buf_we_o) && ($past(buf_addr_o) == FINAL_ADDR)));

    // R3: writes stay inside the two windows' area.
    assert_addr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we_o |-> (buf_addr_o <= FINAL_ADDR));

endmodule

// File: tb/sim_gicap_top.sv
module sim_gicap_top;

    localparam int NB  = 4;
    localparam int SW  = 32;
    localparam int GI  = 4;
    localparam int UL  = 16;
    localparam int SYM = GI + UL;
    localparam int AW  = 6;
    localparam int MAXW = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sof = 1'b0;
    logic              valid = 1'b0;
    logic [NB*SW-1:0]  bus = '0;
    logic              we;
    logic [AW-1:0]     addr;
    logic [SW-1:0]     wdata;
    logic              done;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int          exp_addr [MAXW];
    logic [31:0] exp_data [MAXW];
    int          exp_cyc  [MAXW];
    int          n_exp = 0;
    int          log_addr [MAXW];
    logic [31:0] log_data [MAXW];
    int          log_cyc  [MAXW];
    int          n_log = 0;
    int          exp_done [64];
    int          n_expd = 0;
    int          log_done [64];
    int          n_logd = 0;
    int          cur = 0;
    int          curd = 0;

    gicap_top #(
        .NUM_BR (NB), .SAMP_W (SW), .GI_LEN (GI), .USEFUL_LEN (UL), .ADDR_W (AW)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .sym_start_i (sof), .smp_valid_i (valid),
        .smp_bus_i (bus), .buf_we_o (we), .buf_addr_o (addr),
        .buf_wdata_o (wdata), .done_o (done)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Record every write and done strobe away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (we) begin
                if (n_log < MAXW) begin
                    log_addr[n_log] = int'(addr);
                    log_data[n_log] = wdata;
                    log_cyc[n_log]  = cyc;
                end
                n_log++;
            end
            if (done) begin
                if (n_logd < 64) log_done[n_logd] = cyc;
                n_logd++;
            end
        end
    end

    function automatic logic [31:0] dat(input int sym, input int idx, input int b);
        return {8'(8'hA0 + b), 8'(sym), 16'(idx)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_sof();
        @(posedge clk); #1; sof = 1'b1;
        @(posedge clk); #1; sof = 1'b0;
    endtask

    // Present one sample; nexp = number of branch writes expected from it.
    task automatic send(input int sym, input int idx, input bit s, input int nexp,
                        input int gap, input bit sof_next);
        int vc;
        @(posedge clk); #1;
        sof = s; valid = 1'b1;
        for (int b = 0; b < NB; b++) bus[b*SW +: SW] = dat(sym, idx, b);
        vc = cyc;
        if (nexp > 0 && (idx < GI || (idx >= UL && idx < SYM))) begin
            for (int b = 0; b < nexp; b++) begin
                exp_addr[n_exp] = (idx < GI) ? (b*GI + idx) : (NB*GI + b*GI + idx - UL);
                exp_data[n_exp] = dat(sym, idx, b);
                exp_cyc[n_exp]  = vc + 1 + b;
                n_exp++;
            end
            if (nexp == NB && idx == SYM - 1) begin
                exp_done[n_expd] = vc + 1 + NB;
                n_expd++;
            end
        end
        @(posedge clk); #1;
        sof = sof_next; valid = 1'b0;
        bus = {NB{32'(cyc) ^ 32'h5A5A_3C3C}};
        if (sof_next) begin
            @(posedge clk); #1; sof = 1'b0;
            bus = ~bus;
            repeat (gap - 3) @(posedge clk);
        end else begin
            repeat (gap - 2) @(posedge clk);
        end
    endtask

    // Compare everything logged since the previous call with the expectations.
    task automatic verify(input string tag);
        int m;
        idle(12);
        chk(n_log == n_exp, "R4", {tag, " write count"}, n_log, n_exp);
        m = (n_log < n_exp) ? n_log : n_exp;
        for (int k = cur; k < m; k++) begin
            chk(log_addr[k] == exp_addr[k] && log_data[k] == exp_data[k],
                (exp_addr[k] < NB*GI) ? "R2" : "R3", {tag, " address/data"},
                {32'(log_addr[k]), log_data[k]}, {32'(exp_addr[k]), exp_data[k]});
            chk(log_cyc[k] == exp_cyc[k], "R5", {tag, " write cycle"},
                log_cyc[k], exp_cyc[k]);
        end
        chk(n_logd == n_expd, "R8", {tag, " done count"}, n_logd, n_expd);
        m = (n_logd < n_expd) ? n_logd : n_expd;
        for (int k = curd; k < m; k++)
            chk(log_done[k] == exp_done[k], "R8", {tag, " done cycle"},
                log_done[k], exp_done[k]);
        cur  = n_exp;
        curd = n_expd;
    endtask

    initial begin
        // R1: outputs quiet during and just after reset.
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(we == 1'b0 && done == 1'b0, "R1", "outputs in reset", {we, done}, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        chk(we == 1'b0 && done == 1'b0, "R1", "outputs after reset", {we, done}, 0);

        // R9: samples before any symbol-start are ignored.
        for (int i = 0; i < 6; i++) send(9, i, 1'b0, 0, 4, 1'b0);
        verify("R9 before first start");

        // R2 R3 R4 R8: one complete symbol at the tightest spacing.
        pulse_sof();
        for (int i = 0; i < SYM; i++) send(1, i, 1'b0, NB, 4, 1'b0);
        verify("R2 R3 full symbol");

        // R9: samples after a completed symbol and before the next start are ignored.
        for (int i = 0; i < 6; i++) send(2, i, 1'b0, 0, 4, 1'b0);
        verify("R9 after complete symbol");

        // R6: irregular gaps with garbage on the bus while valid is low.
        pulse_sof();
        for (int i = 0; i < SYM; i++) send(3, i, 1'b0, NB, 4 + (i % 3) * 3, 1'b0);
        verify("R6 valid gaps");

        // R7: restart after the head, then cancel writes mid-sample.
        pulse_sof();
        for (int i = 0; i < 12; i++) send(4, i, 1'b0, NB, 4, 1'b0);
        idle(3);
        pulse_sof();
        send(5, 0, 1'b0, NB, 4, 1'b0);
        send(5, 1, 1'b0, NB, 4, 1'b0);
        send(5, 2, 1'b0, 1, 4, 1'b1);
        verify("R7 restart and cancel");

        // R10: a start pulse together with a sample makes that sample index 0.
        for (int i = 0; i < 3; i++) send(6, i, 1'b0, NB, 4, 1'b0);
        send(7, 0, 1'b1, NB, 4, 1'b0);
        for (int i = 1; i < SYM; i++) send(7, i, 1'b0, NB, 5, 1'b0);
        verify("R10 start with sample");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule